// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block drives several independent pulse-width-modulated outputs, each set up through one 32-bit configuration word that software writes and reads over a simple memory-mapped bus. A channel divides the block clock by a programmable amount. It then steps an 8-bit position counter once per divided tick, so each output period is 256 ticks long. The output is active while the position is below the programmed duty. A separate bit holds the output active for the whole period, and an enable bit gates the channel.

Configuration changes apply at once. A write to a channel restarts its divider and position counter, so the new settings apply from the next clock. Clearing the enable bit forces the output inactive at that same edge and does not wait for the period to finish. The highest output frequency is the block clock divided by 256. The number of channels and the address width are parameters.

Top module: `pwm_bank`

## Requirements
- R1: While reset is asserted, and right after it, every output is low and every channel reads back as zero.
- R2: The configuration word has the divider in bits [12:0], the duty in bits [23:16], the force-full bit at bit 24 and the enable bit at bit 31. A read returns the stored word with all other bits zero. Read data appears in the cycle after the read strobe.
- R3: Channel c answers only at byte address c*16. A write to any other address changes no channel. A read of any other address returns zero.
- R4: With the channel enabled and force-full clear, the output is high in the first duty*(divider+1) clocks of each period and low for the rest. A duty of 0 gives a constant low output.
- R5: One period lasts 256*(divider+1) clocks. A divider field of 0 means the position advances every clock.
- R6: With the channel enabled and force-full set, the output stays high for the whole period, whatever the duty field holds.
- R7: With the enable bit clear, the output is low. A write that clears the enable bit drives the output low from the very next clock.
- R8: A write to a channel restarts its period. In the first clock after the write, the output is high exactly when the channel is enabled and either force-full is set or the duty is above zero. The output then follows R4 from that point.
- R9: A write to one channel leaves the configuration and the output of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the source of the divided ticks |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDRW | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after the strobe |
| pwm_out | output | NCH | One modulated output per channel |

## Verification
A fault in a channel's divider or position counter changes the high time or the period length. The stretch where the output should be high comes out too long or too short, or the edge that starts the next period moves, within one period of at most 256*(divider+1) clocks. A fault in the restart or enable logic shows up as a wrong output level in the very first clock after the write. A fault in the field masking or the address decode shows up in the next read-back of any channel.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH   = 4,
  parameter int ADDRW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDRW-1:0]   bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic [NCH-1:0]     pwm_out
);
  localparam int DIVW = 13;
  localparam int DUTYW = 8;
  localparam int EN_BIT = 31;
  localparam int FULL_BIT = 24;
  localparam int DUTY_LSB = 16;
  localparam logic [31:0] FIELD_MASK = 32'h81FF_1FFF;

  logic [NCH-1:0]        hit;
  logic [NCH-1:0][31:0]  rd_term;
  logic [31:0]           rd_mux;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [31:0]       cfg;
    logic [DIVW-1:0]   pre;
    logic [DUTYW-1:0]  pos;
    logic [DIVW-1:0]   div_f;
    logic [DUTYW-1:0]  duty_f;

    assign hit[c]     = (bus_addr == ADDRW'(c * 16));
    assign div_f      = cfg[DIVW-1:0];
    assign duty_f     = cfg[DUTY_LSB +: DUTYW];
    assign rd_term[c] = hit[c] ? cfg : 32'd0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg <= '0;
        pre <= '0;
        pos <= '0;
      end else if (bus_wr && hit[c]) begin
        cfg <= bus_wdata & FIELD_MASK;
        pre <= '0;
        pos <= '0;
      end else if (!cfg[EN_BIT]) begin
        pre <= '0;
        pos <= '0;
      end else if (pre == div_f) begin
        pre <= '0;
        pos <= pos + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end

    assign pwm_out[c] = cfg[EN_BIT] & (cfg[FULL_BIT] | (pos < duty_f));
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) rd_mux = rd_mux | rd_term[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH   = 4,
  parameter int ADDRW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDRW-1:0]   bus_addr,
  input logic               bus_wr,
  input logic [31:0]        bus_wdata,
  input logic               bus_rd,
  input logic [31:0]        bus_rdata,
  input logic [NCH-1:0]     pwm_out
);
  localparam logic [31:0] FIELD_MASK = 32'h81FF_1FFF;

  logic addr_ok;
  always_comb begin
    addr_ok = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (bus_addr == ADDRW'(c * 16)) addr_ok = 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (pwm_out == '0)); // R1

  AST_BAD_ADDR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_ok) |=> (bus_rdata == 32'd0)); // R3

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam logic [ADDRW-1:0] A = ADDRW'(c * 16);

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A && !bus_wdata[31]) |=> !pwm_out[c]); // R7

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A && bus_wdata[31] && bus_wdata[24]) |=> pwm_out[c]); // R6

    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A && bus_wdata[31] && bus_wdata[23:16] != 8'd0) |=> pwm_out[c]); // R8

    AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A && bus_wdata[31] && !bus_wdata[24] && bus_wdata[23:16] == 8'd0)
      |=> !pwm_out[c]); // R4

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_wr) && $past(bus_addr) == A && bus_rd && !bus_wr && bus_addr == A)
      |=> (bus_rdata == ($past(bus_wdata, 2) & FIELD_MASK))); // R2
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .ADDRW(ADDRW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
);

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;
  localparam int NCH = 4;
  localparam int ADDRW = 8;
  localparam logic [31:0] MASK = 32'h81FF_1FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDRW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [NCH];

  always #2.5 clk = ~clk;

  pwm_bank #(.NCH(NCH), .ADDRW(ADDRW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic bit level(input logic [31:0] r, input int i);
    int div;
    div = int'(r[12:0]) + 1;
    if (!r[31]) return 1'b0;
    if (r[24]) return 1'b1;
    return ((i / div) % 256) < int'(r[23:16]);
  endfunction

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = ADDRW'(addr); bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (addr == c * 16) model[c] = data & MASK;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = ADDRW'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = bus_rdata;
  endtask

  task automatic check_all_regs(input string req);
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      rd(c * 16, v);
      check(v === model[c], req, v, model[c]);
    end
  endtask

  // Called right after a write: sample index 0 is the first clock after it.
  task automatic measure(input int c, input string req);
    logic [31:0] r;
    int n, mism, highs, exp_h;
    r = model[c];
    n = 256 * (int'(r[12:0]) + 1);
    mism = 0; highs = 0; exp_h = 0;
    check(pwm_out[c] === level(r, 0), "R8 first clock after write",
          32'(pwm_out[c]), 32'(level(r, 0)));
    for (int i = 0; i <= n; i++) begin
      if (pwm_out[c] !== level(r, i)) mism++;
      if (pwm_out[c] === 1'b1) highs++;
      if (level(r, i)) exp_h++;
      @(negedge clk);
    end
    check(mism == 0, req, 32'(mism), 32'd0);
    check(highs == exp_h, "R5 high clocks over one period plus one", 32'(highs), 32'(exp_h));
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) model[c] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(pwm_out === '0, "R1 outputs in reset", 32'(pwm_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out === '0, "R1 outputs after reset", 32'(pwm_out), 32'd0);
    check_all_regs("R1 registers after reset");

    // R2: field masking and read-back
    wr(2 * 16, 32'hFFFF_FFFF);
    rd(2 * 16, v);
    check(v === 32'h81FF_1FFF, "R2 masked read-back", v, 32'h81FF_1FFF);
    wr(2 * 16, 32'h0000_0000);

    // R4/R5: duty and divider
    wr(0, 32'h8080_0000);
    measure(0, "R4 half duty divider 0");
    wr(16, 32'h8001_0003);
    measure(1, "R5 duty 1 divider 3");
    wr(16, 32'h80FF_0002);
    measure(1, "R4 duty 255 divider 2");
    wr(32, 32'h8000_0001);
    measure(2, "R4 duty 0 stays low");

    // R6: force full ignores duty
    wr(48, 32'h8105_0001);
    measure(3, "R6 force full");

    // R9: channel 3 is still full high while channel 0 changes
    wr(0, 32'h8040_0000);
    check(pwm_out[3] === 1'b1, "R9 other channel output kept", 32'(pwm_out[3]), 32'd1);
    check_all_regs("R9 other registers kept");

    // R7: disable cuts the period
    wr(0, 32'h8180_0000);
    repeat (5) @(negedge clk);
    check(pwm_out[0] === 1'b1, "R6 full before disable", 32'(pwm_out[0]), 32'd1);
    wr(0, 32'h0180_0000);
    check(pwm_out[0] === 1'b0, "R7 low right after disable", 32'(pwm_out[0]), 32'd0);
    measure(0, "R7 disabled stays low");

    // R8: rewrite mid-period restarts
    wr(16, 32'h800A_0001);
    repeat (7) @(negedge clk);
    check(pwm_out[1] === 1'b1, "R4 mid-period high", 32'(pwm_out[1]), 32'd1);
    wr(16, 32'h8004_0001);
    measure(1, "R8 restart after mid-period write");

    // R3: ignored addresses
    wr(NCH * 16, 32'hFFFF_FFFF);
    wr(5, 32'hFFFF_FFFF);
    wr(16 + 3, 32'hFFFF_FFFF);
    wr(255, 32'hFFFF_FFFF);
    check_all_regs("R3 stray writes ignored");
    rd(NCH * 16, v);
    check(v === 32'd0, "R3 stray read returns zero", v, 32'd0);
    rd(9, v);
    check(v === 32'd0, "R3 unaligned read returns zero", v, 32'd0);

    // Random mix
    for (int k = 0; k < 30; k++) begin
      int c;
      logic [31:0] d;
      c = int'($urandom % NCH);
      d = $urandom;
      d[12:0] = 13'($urandom % 4);
      if (($urandom % 8) == 0) d[31] = 1'b0; else d[31] = 1'b1;
      if (($urandom % 6) != 0) d[24] = 1'b0;
      wr(c * 16, d);
      measure(c, "R4 random configuration");
      check_all_regs("R2 random read-back");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule